// File: doc/BRIEF.md
# Isochronous Audio Packet Header Generator

This block forms the two 32-bit header words that lead every outgoing isochronous audio packet. For each packet the caller pulses a strobe together with the number of audio events in the packet, the channel count, the local node ID, a sample-rate code and the timestamp interval for that rate. One clock later both header words appear together, qualified by a single-cycle valid pulse.

Between packets the block holds a running data block counter and the timing state behind the presentation timestamp. That state is a 4-bit cycle count and a tick offset with an exact fractional part whose denominator is the sample rate. A packet gets a real timestamp only when it carries the event that falls on a timestamp-interval boundary. When that happens the offset advances by the exact tick span of one interval, and every full 3072 ticks carry into the cycle count. Any other packet carries the "no timestamp" code. Reset starts a stream: the counter goes to zero and the timing state is preloaded with a 9000-tick transfer delay.

Top module: `cip_hdr_gen`

## Requirements
- R1: After reset `hdr_vld` is 0 and both header words are 0. The data block count restarts at 0. The timing state holds 9000 ticks, so the first emitted timestamp is 0x2B28 (cycle 2, offset 2856).
- R2: `hdr_vld` is high for exactly one cycle, in the cycle after each cycle in which `pkt_stb` is high. It is never high otherwise. Both header words change together with it.
- R3: Header word 0, most significant bit first, is: bits 31:30 = 0; bits 29:24 = `node_id[5:0]`; bits 23:16 = `dim`; bits 15:8 = 0; bits 7:0 = the data block count before this packet.
- R4: Header word 1 has bits 31:30 = 2'b10 and bits 29:24 = 6'h10. Bits 23:16 hold `rate_code` zero-extended, where codes 0..6 stand for 32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz.
- R5: After each packet the data block count advances by `evt_cnt`, modulo 256. A packet with zero events leaves it unchanged.
- R6: The timestamped position is (`syt_ivl` − count) AND (`syt_ivl` − 1), computed on 8 bits. When that position is not below `evt_cnt`, bits 15:0 of word 1 are 0xFFFF and the timing state does not move.
- R7: Otherwise bits 15:0 of word 1 are {cycle[3:0], offset[11:0]}. The offset then grows by 24,576,000 × `syt_ivl` / rate ticks, with the fractional remainder kept exactly. Every 3072 ticks carry into the 4-bit cycle count, which wraps modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts a new stream |
| pkt_stb | input | 1 | One packet per high cycle |
| evt_cnt | input | 8 | Events carried by this packet |
| dim | input | 8 | Quadlets per event (channel count) |
| node_id | input | 16 | Local node ID; low 6 bits form the source ID |
| rate_code | input | 3 | Sample-rate code 0..6 |
| syt_ivl | input | 6 | Events between timestamps: 8, 16 or 32 |
| hdr_q0 | output | 32 | Header word 0 |
| hdr_q1 | output | 32 | Header word 1 |
| hdr_vld | output | 1 | One-cycle qualifier for the header words |

## Verification
The checker takes for granted that `syt_ivl` is a power of two that matches `rate_code` (8 up to 48 kHz, 16 at 88.2/96 kHz, 32 above that). It also assumes the rate stays fixed between resets, since the fractional remainder is only meaningful against one denominator. The stimulus respects both: each rate group starts with a reset and drives only that rate's own interval. Within a group it alternates full-interval and empty packets, then sends fractional per-cycle event counts, both back-to-back and with idle gaps. The runs are long enough to wrap the data block counter and the cycle count.

// File: rtl/cip_hdr_pkg.sv
package cip_hdr_pkg;
  localparam int NUM_RATES       = 7;
  localparam int CODE_W          = 3;
  localparam int TICK_HZ         = 24576000;
  localparam int TICKS_PER_CYCLE = 3072;
  localparam int XFER_DELAY      = 9000;

  localparam logic [1:0]  EOH_FIRST  = 2'b00;
  localparam logic [1:0]  EOH_SECOND = 2'b10;
  localparam logic [5:0]  FMT_AUDIO  = 6'h10;
  localparam logic [15:0] NO_STAMP   = 16'hFFFF;

  function automatic int rate_hz(input int code);
    case (code)
      1:       return 44100;
      2:       return 48000;
      3:       return 88200;
      4:       return 96000;
      5:       return 176400;
      6:       return 192000;
      default: return 32000;
    endcase
  endfunction

  function automatic int ivl_for(input int code);
    if (code >= 5)      return 32;
    else if (code >= 3) return 16;
    else                return 8;
  endfunction
endpackage

// File: rtl/cip_tick_inc.sv
module cip_tick_inc #(
  parameter int OFF_W = 14,
  parameter int REM_W = 18
) (
  input  logic [cip_hdr_pkg::CODE_W-1:0] rate_code,
  output logic [OFF_W-1:0]               inc_int,
  output logic [REM_W-1:0]               inc_rem,
  output logic [REM_W-1:0]               den
);
  import cip_hdr_pkg::*;
  localparam int ENTRIES = 2 ** CODE_W;

  logic [OFF_W-1:0] int_tab [ENTRIES];
  logic [REM_W-1:0] rem_tab [ENTRIES];
  logic [REM_W-1:0] den_tab [ENTRIES];

  // Unused codes fall back to the lowest rate.
  for (genvar c = 0; c < ENTRIES; c++) begin : g_rate
    localparam int     EFF  = (c < NUM_RATES) ? c : 0;
    localparam longint HZ   = longint'(rate_hz(EFF));
    localparam longint SPAN = longint'(TICK_HZ) * longint'(ivl_for(EFF));
    assign int_tab[c] = OFF_W'(SPAN / HZ);
    assign rem_tab[c] = REM_W'(SPAN % HZ);
    assign den_tab[c] = REM_W'(HZ);
  end

  assign inc_int = int_tab[rate_code];
  assign inc_rem = rem_tab[rate_code];
  assign den     = den_tab[rate_code];
endmodule

// File: rtl/cip_ts_accum.sv
module cip_ts_accum #(
  parameter int OFF_W = 14,
  parameter int REM_W = 18,
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [OFF_W-1:0] inc_int,
  input  logic [REM_W-1:0] inc_rem,
  input  logic [REM_W-1:0] den,
  output logic [15:0]      stamp
);
  import cip_hdr_pkg::*;
  localparam int               MAX_WRAP = 3;
  localparam logic [OFF_W-1:0] TPC      = OFF_W'(TICKS_PER_CYCLE);
  localparam logic [OFF_W-1:0] OFF_INIT = OFF_W'(XFER_DELAY % TICKS_PER_CYCLE);
  localparam logic [CYC_W-1:0] CYC_INIT = CYC_W'(XFER_DELAY / TICKS_PER_CYCLE);

  logic [CYC_W-1:0] cyc_q, cyc_nxt;
  logic [OFF_W-1:0] off_q, off_sum, off_nxt;
  logic [REM_W-1:0] rem_q, rem_nxt;
  logic [REM_W:0]   rem_sum;
  logic             carry;

  always_comb begin
    rem_sum = {1'b0, rem_q} + {1'b0, inc_rem};
    carry   = rem_sum >= {1'b0, den};
    rem_nxt = carry ? REM_W'(rem_sum - {1'b0, den}) : rem_sum[REM_W-1:0];
    off_sum = off_q + inc_int + OFF_W'(carry);
    off_nxt = off_sum;
    cyc_nxt = cyc_q;
    for (int k = 0; k < MAX_WRAP; k++) begin
      if (off_nxt >= TPC) begin
        off_nxt = off_nxt - TPC;
        cyc_nxt = cyc_nxt + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= CYC_INIT;
      off_q <= OFF_INIT;
      rem_q <= '0;
    end else if (adv) begin
      cyc_q <= cyc_nxt;
      off_q <= off_nxt;
      rem_q <= rem_nxt;
    end
  end

  assign stamp = {cyc_q[3:0], off_q[11:0]};
endmodule

// File: rtl/cip_hdr_gen.sv
module cip_hdr_gen #(
  parameter int OFF_W = 14,
  parameter int REM_W = 18,
  parameter int CYC_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pkt_stb,
  input  logic [7:0]  evt_cnt,
  input  logic [7:0]  dim,
  input  logic [15:0] node_id,
  input  logic [2:0]  rate_code,
  input  logic [5:0]  syt_ivl,
  output logic [31:0] hdr_q0,
  output logic [31:0] hdr_q1,
  output logic        hdr_vld
);
  import cip_hdr_pkg::*;

  logic [OFF_W-1:0] inc_int;
  logic [REM_W-1:0] inc_rem, den;
  logic [15:0]      stamp;
  logic [7:0]       dbc_q, ivl8, ts_idx;
  logic             ts_hit;

  cip_tick_inc #(.OFF_W(OFF_W), .REM_W(REM_W)) u_inc (
    .rate_code (rate_code),
    .inc_int   (inc_int),
    .inc_rem   (inc_rem),
    .den       (den)
  );

  assign ivl8   = {2'b00, syt_ivl};
  assign ts_idx = (ivl8 - dbc_q) & (ivl8 - 8'd1);
  assign ts_hit = ts_idx < evt_cnt;

  cip_ts_accum #(.OFF_W(OFF_W), .REM_W(REM_W), .CYC_W(CYC_W)) u_ts (
    .clk     (clk),
    .rst     (rst),
    .adv     (pkt_stb & ts_hit),
    .inc_int (inc_int),
    .inc_rem (inc_rem),
    .den     (den),
    .stamp   (stamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dbc_q   <= '0;
      hdr_q0  <= '0;
      hdr_q1  <= '0;
      hdr_vld <= 1'b0;
    end else begin
      hdr_vld <= pkt_stb;
      if (pkt_stb) begin
        dbc_q  <= dbc_q + evt_cnt;
        hdr_q0 <= {EOH_FIRST, node_id[5:0], dim, 8'h00, dbc_q};
        hdr_q1 <= {EOH_SECOND, FMT_AUDIO, 5'b00000, rate_code,
                   ts_hit ? stamp : NO_STAMP};
      end
    end
  end
endmodule

// File: rtl/cip_hdr_chk.sv
module cip_hdr_chk (
  input logic        clk,
  input logic        rst,
  input logic        pkt_stb,
  input logic [7:0]  evt_cnt,
  input logic [7:0]  dim,
  input logic [15:0] node_id,
  input logic [2:0]  rate_code,
  input logic [5:0]  syt_ivl,
  input logic [31:0] hdr_q0,
  input logic [31:0] hdr_q1,
  input logic        hdr_vld
);
  logic [7:0] evt_seen, dbc_pred;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_seen <= '0;
      dbc_pred <= '0;
    end else begin
      if (pkt_stb) evt_seen <= evt_cnt;
      if (hdr_vld) dbc_pred <= hdr_q0[7:0] + evt_seen;
    end
  end

  p_vld_follows_stb_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_stb |=> hdr_vld);
  p_no_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !pkt_stb |=> !hdr_vld);
  p_q0_zero_fields_r3: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> (hdr_q0[31:30] == 2'b00 && hdr_q0[15:8] == 8'h00));
  p_q1_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> (hdr_q1[31:24] == 8'h90 && hdr_q1[23:19] == 5'd0));
  p_dbc_step_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> hdr_q0[7:0] == dbc_pred);
  p_no_stamp_rule_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_stb |=> ((8'(({2'b00, $past(syt_ivl)} - hdr_q0[7:0]) &
                     ({2'b00, $past(syt_ivl)} - 8'd1)) >= $past(evt_cnt))
                 == (hdr_q1[15:0] == 16'hFFFF)));
  p_offset_range_r7: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && hdr_q1[15:0] != 16'hFFFF) |-> hdr_q1[11:0] < 12'd3072);
endmodule

bind cip_hdr_gen cip_hdr_chk u_chk (.*);

// File: tb/sim_cip_hdr_gen.sv
module sim_cip_hdr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_stb = 1'b0;
  logic [7:0]  evt_cnt = '0;
  logic [7:0]  dim = 8'd2;
  logic [15:0] node_id = 16'hFFC5;
  logic [2:0]  rate_code = '0;
  logic [5:0]  syt_ivl = 6'd8;
  logic [31:0] hdr_q0, hdr_q1;
  logic        hdr_vld;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [64:0] expq[$];
  int     m_dbc, m_hz, m_ivl, m_acc;
  longint m_t;

  always #10 clk = ~clk;

  cip_hdr_gen u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && hdr_vld) begin
      if (expq.size() == 0) chk(1'b0, "R2 unexpected valid", {31'd0, hdr_vld}, 32'd0);
      else begin
        logic [64:0] e;
        e = expq.pop_front();
        chk(hdr_q0[31:8] == e[63:40], "R3 word0 fields", {8'h0, hdr_q0[31:8]}, {8'h0, e[63:40]});
        chk(hdr_q0[7:0] == e[39:32], "R5 data block count", {24'h0, hdr_q0[7:0]}, {24'h0, e[39:32]});
        chk(hdr_q1[31:16] == e[31:16], "R4 word1 fixed and rate", {16'h0, hdr_q1[31:16]}, {16'h0, e[31:16]});
        if (e[64]) chk(hdr_q1[15:0] == e[15:0], "R7 timestamp", {16'h0, hdr_q1[15:0]}, {16'h0, e[15:0]});
        else       chk(hdr_q1[15:0] == e[15:0], "R6 no timestamp", {16'h0, hdr_q1[15:0]}, {16'h0, e[15:0]});
      end
    end
  end

  task automatic send(input int evt);
    int idx, cyc, off;
    logic [15:0] syt;
    bit emit;
    @(negedge clk);
    evt_cnt = 8'(evt);
    pkt_stb = 1'b1;
    idx = (m_ivl - m_dbc) & (m_ivl - 1);
    emit = idx < evt;
    if (emit) begin
      cyc = int'((m_t / (longint'(3072) * m_hz)) % 16);
      off = int'((m_t / m_hz) % 3072);
      syt = 16'((cyc << 12) | off);
      m_t += longint'(24576000) * m_ivl;
    end else syt = 16'hFFFF;
    expq.push_back({emit, 2'b00, node_id[5:0], dim, 8'h00, 8'(m_dbc),
                    8'h90, 5'd0, rate_code, syt});
    m_dbc = (m_dbc + evt) % 256;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      pkt_stb = 1'b0;
    end
  endtask

  task automatic restart(input int code);
    @(negedge clk);
    pkt_stb = 1'b0;
    rst = 1'b1;
    rate_code = 3'(code);
    m_hz  = (code == 1) ? 44100 : (code == 2) ? 48000 : (code == 3) ? 88200 :
            (code == 4) ? 96000 : (code == 5) ? 176400 : (code == 6) ? 192000 : 32000;
    m_ivl = (code >= 5) ? 32 : (code >= 3) ? 16 : 8;
    syt_ivl = 6'(m_ivl);
    repeat (3) @(negedge clk);
    chk(hdr_vld == 1'b0, "R1 valid in reset", {31'd0, hdr_vld}, 32'd0);
    chk(hdr_q0 == 32'd0, "R1 word0 in reset", hdr_q0, 32'd0);
    chk(hdr_q1 == 32'd0, "R1 word1 in reset", hdr_q1, 32'd0);
    rst = 1'b0;
    m_dbc = 0;
    m_acc = 0;
    m_t = longint'(9000) * m_hz;
  endtask

  task automatic run_group(input int code, input int nblk, input int nfree);
    restart(code);
    for (int i = 0; i < nblk; i++) begin
      send((i % 3 == 2) ? 0 : m_ivl);
      if (i % 4 == 3) idle(2);
    end
    for (int i = 0; i < nfree; i++) begin
      m_acc += m_hz;
      send(m_acc / 8000);
      m_acc = m_acc % 8000;
      if (i % 5 == 4) idle(1);
    end
    idle(3);
    chk(expq.size() == 0, "R2 all packets answered", expq.size(), 32'd0);
  endtask

  initial begin
    restart(2);
    send(8);
    idle(1);
    chk(hdr_vld == 1'b1, "R2 valid after strobe", {31'd0, hdr_vld}, 32'd1);
    chk(hdr_q1[15:0] == 16'h2B28, "R1 first timestamp", {16'h0, hdr_q1[15:0]}, 32'h2B28);
    idle(1);
    chk(hdr_vld == 1'b0, "R2 single-cycle valid", {31'd0, hdr_vld}, 32'd0);
    run_group(1, 60, 120);
    dim = 8'd6; node_id = 16'h1234;
    run_group(2, 50, 90);
    run_group(3, 40, 80);
    dim = 8'd2; node_id = 16'h003F;
    run_group(6, 40, 60);
    run_group(0, 30, 60);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule